// File: doc/BRIEF.md
# Interrupt Gating and Cycle Timers

This block sits beside a processor's control registers. It combines the global interrupt enable fields of the status word with two external request sources: a general interrupt controller (a status word and a mask word) and a DMA controller (a status half-word and a mask half-word). It also keeps a free-running cycle count with a compare register, and two performance counters that count clock cycles.

Each of the three outgoing requests uses a valid/ready handshake. The `*_pend` or `tmr_req` output is the valid signal and the matching `*_ack` input is the ready signal. A request that has been raised stays high until the consumer accepts it by holding ack high on a clock edge. A stalled consumer simply leaves ack low, and the request waits without being lost or duplicated.

All counter and compare writes share one data bus, with a separate write strobe for each target. Each counter register is visible on its own output pin.

Top module: `irq_gate_timer`

## Requirements
- R1: The controller and DMA requests may be raised only while `status_in & 32'h0001_0007` equals `32'h0001_0001`, meaning bit 0 and bit 16 are set and bits 1 and 2 are clear.
- R2: With R1 met, `ictl_pend` is raised one clock edge after a cycle in which `status_in[10]` is 1 and `ictl_stat & ictl_mask` is nonzero.
- R3: With R1 met, `dma_pend` is raised one edge after a cycle in which `status_in[11]` is 1 and either `dmac_stat & dmac_mask` is nonzero or `dmac_stat[15]` is 1. Bit 15 raises the request even when its mask bit is 0.
- R4: A raised request stays high while its ack is low, whatever its condition does. An edge with ack high clears it. The request is raised again on the following edge if its condition still holds.
- R5: `count_o` increments by one on every edge and wraps modulo 2^32. On an edge where `cnt_we` is 1, it loads `wr_data` instead.
- R6: `compare_o` loads `wr_data` on an edge where `cmp_we` is 1. `tmr_req` is raised one edge after a cycle in which `status_in[15]` is 1, `count_o >= compare_o`, and `count_o < compare_o + 1000`. The sum is taken modulo 2^32, so a compare value near the top of the range gives an empty window. The timer does not depend on R1.
- R7: `tmr_cause` reads `32'h0080_8000` while `tmr_req` is high and zero otherwise.
- R8: `pc0_o` increments on each edge where `pcc_in & 32'h8000_03E0` equals `32'h8000_0020`, and holds otherwise. `pc0_we` loads `wr_data`, and a write wins over counting.
- R9: `pc1_o` increments on each edge where `pcc_in & 32'h800F_8000` equals `32'h8000_8000`, and holds otherwise. `pc1_we` loads `wr_data`, and a write wins over counting.
- R10: While `rst_n` is low, every request output and every counter, compare and cause output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_in | input | 32 | Processor status word |
| ictl_stat | input | IW | Interrupt controller status |
| ictl_mask | input | IW | Interrupt controller mask |
| dmac_stat | input | DW | DMA controller status half |
| dmac_mask | input | DW | DMA controller mask half |
| pcc_in | input | 32 | Performance counter control |
| wr_data | input | TW | Shared write data |
| cmp_we | input | 1 | Load compare register |
| cnt_we | input | 1 | Load cycle count |
| pc0_we | input | 1 | Load performance counter 0 |
| pc1_we | input | 1 | Load performance counter 1 |
| ictl_ack | input | 1 | Ready for the controller request |
| dma_ack | input | 1 | Ready for the DMA request |
| tmr_ack | input | 1 | Ready for the timer request |
| ictl_pend | output | 1 | Controller request valid |
| dma_pend | output | 1 | DMA request valid |
| tmr_req | output | 1 | Timer exception request valid |
| tmr_cause | output | 32 | Cause code of the timer request |
| count_o | output | TW | Cycle count |
| compare_o | output | TW | Compare value |
| pc0_o | output | TW | Performance counter 0 |
| pc1_o | output | TW | Performance counter 1 |

## Verification
A corrupted request latch shows up one edge later, either as a request that never drops after ack or as one that appears with no enabling status pattern. A counter that skips, sticks or ignores its enable pattern drifts from the arithmetic expectation on every following edge. That drift becomes visible within a few cycles of a load. A faulty window bound only shows at the exact boundary offsets, so the sweep places the count at one below compare, at compare, at the last and first-excluded offsets, and at compare values whose upper bound wraps.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  // status word fields used for gating
  localparam logic [31:0] ST_GATE_MASK = 32'h0001_0007;
  localparam logic [31:0] ST_GATE_VAL  = 32'h0001_0001;
  localparam int          ST_ICTL_EN   = 10;
  localparam int          ST_DMA_EN    = 11;
  localparam int          ST_TMR_EN    = 15;
  // timer exception cause code
  localparam logic [31:0] TMR_CAUSE    = 32'h0080_8000;
  // performance control patterns selecting cycle counting
  localparam logic [31:0] PC0_SEL_MASK = 32'h8000_03E0;
  localparam logic [31:0] PC0_SEL_VAL  = 32'h8000_0020;
  localparam logic [31:0] PC1_SEL_MASK = 32'h800F_8000;
  localparam logic [31:0] PC1_SEL_VAL  = 32'h8000_8000;
  // request and counter slot indices
  localparam int REQ_ICTL = 0;
  localparam int REQ_DMA  = 1;
  localparam int REQ_TMR  = 2;
  localparam int NREQ     = 3;
  localparam int CTR_CNT  = 0;
  localparam int CTR_PC0  = 1;
  localparam int CTR_PC1  = 2;
  localparam int NCTR     = 3;
endpackage

// File: rtl/irqt_req_latch.sv
module irqt_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic ack,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend <= 1'b0;
    else if (pend)       pend <= !ack;
    else if (cond)       pend <= 1'b1;
  end
endmodule

// File: rtl/irqt_cyc_ctr.sv
module irqt_cyc_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (we)  q <= wdata;
    else if (en)  q <= q + W'(1);
  end
endmodule

// File: rtl/irqt_win_cmp.sv
module irqt_win_cmp #(
  parameter int W   = 32,
  parameter int WIN = 1000
) (
  input  logic [W-1:0] count,
  input  logic [W-1:0] compare,
  output logic         hit
);
  logic [W-1:0] upper;
  // upper bound wraps modulo 2^W on purpose
  assign upper = compare + W'(WIN);
  assign hit   = (count >= compare) && (count < upper);
endmodule

// File: rtl/irq_gate_timer.sv
module irq_gate_timer
  import irqt_pkg::*;
#(
  parameter int IW  = 32,
  parameter int DW  = 16,
  parameter int TW  = 32,
  parameter int WIN = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   status_in,
  input  logic [IW-1:0] ictl_stat,
  input  logic [IW-1:0] ictl_mask,
  input  logic [DW-1:0] dmac_stat,
  input  logic [DW-1:0] dmac_mask,
  input  logic [31:0]   pcc_in,
  input  logic [TW-1:0] wr_data,
  input  logic          cmp_we,
  input  logic          cnt_we,
  input  logic          pc0_we,
  input  logic          pc1_we,
  input  logic          ictl_ack,
  input  logic          dma_ack,
  input  logic          tmr_ack,
  output logic          ictl_pend,
  output logic          dma_pend,
  output logic          tmr_req,
  output logic [31:0]   tmr_cause,
  output logic [TW-1:0] count_o,
  output logic [TW-1:0] compare_o,
  output logic [TW-1:0] pc0_o,
  output logic [TW-1:0] pc1_o
);
  localparam int DMA_ALL_BIT = DW - 1;

  logic            gate_ok;
  logic            win_hit;
  logic [NREQ-1:0] req_cond, req_ack, req_pend;
  logic [NCTR-1:0] ctr_en, ctr_we;
  logic [TW-1:0]   ctr_q [NCTR];
  logic [TW-1:0]   cmp_q;

  assign gate_ok = (status_in & ST_GATE_MASK) == ST_GATE_VAL;

  irqt_win_cmp #(.W(TW), .WIN(WIN)) u_win (
    .count(ctr_q[CTR_CNT]), .compare(cmp_q), .hit(win_hit)
  );

  assign req_cond[REQ_ICTL] = gate_ok && status_in[ST_ICTL_EN] && |(ictl_stat & ictl_mask);
  assign req_cond[REQ_DMA]  = gate_ok && status_in[ST_DMA_EN]
                              && (|(dmac_stat & dmac_mask) || dmac_stat[DMA_ALL_BIT]);
  assign req_cond[REQ_TMR]  = status_in[ST_TMR_EN] && win_hit;

  assign req_ack[REQ_ICTL] = ictl_ack;
  assign req_ack[REQ_DMA]  = dma_ack;
  assign req_ack[REQ_TMR]  = tmr_ack;

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    irqt_req_latch u_lat (
      .clk(clk), .rst_n(rst_n), .cond(req_cond[g]), .ack(req_ack[g]), .pend(req_pend[g])
    );
  end

  assign ctr_en[CTR_CNT] = 1'b1;
  assign ctr_en[CTR_PC0] = (pcc_in & PC0_SEL_MASK) == PC0_SEL_VAL;
  assign ctr_en[CTR_PC1] = (pcc_in & PC1_SEL_MASK) == PC1_SEL_VAL;
  assign ctr_we[CTR_CNT] = cnt_we;
  assign ctr_we[CTR_PC0] = pc0_we;
  assign ctr_we[CTR_PC1] = pc1_we;

  for (genvar c = 0; c < NCTR; c++) begin : g_ctr
    irqt_cyc_ctr #(.W(TW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .en(ctr_en[c]), .we(ctr_we[c]),
      .wdata(wr_data), .q(ctr_q[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_we) cmp_q <= wr_data;
  end

  assign ictl_pend = req_pend[REQ_ICTL];
  assign dma_pend  = req_pend[REQ_DMA];
  assign tmr_req   = req_pend[REQ_TMR];
  assign tmr_cause = tmr_req ? TMR_CAUSE : 32'h0;
  assign count_o   = ctr_q[CTR_CNT];
  assign compare_o = cmp_q;
  assign pc0_o     = ctr_q[CTR_PC0];
  assign pc1_o     = ctr_q[CTR_PC1];
endmodule

// File: rtl/irqt_chk.sv
module irqt_chk
  import irqt_pkg::*;
#(
  parameter int IW  = 32,
  parameter int DW  = 16,
  parameter int TW  = 32,
  parameter int WIN = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   status_in,
  input logic [IW-1:0] ictl_stat,
  input logic [IW-1:0] ictl_mask,
  input logic [DW-1:0] dmac_stat,
  input logic [DW-1:0] dmac_mask,
  input logic [31:0]   pcc_in,
  input logic [TW-1:0] wr_data,
  input logic          cnt_we,
  input logic          pc0_we,
  input logic          pc1_we,
  input logic          ictl_ack,
  input logic          dma_ack,
  input logic          tmr_ack,
  input logic          ictl_pend,
  input logic          dma_pend,
  input logic          tmr_req,
  input logic [31:0]   tmr_cause,
  input logic [TW-1:0] count_o,
  input logic [TW-1:0] compare_o,
  input logic [TW-1:0] pc0_o,
  input logic [TW-1:0] pc1_o
);
  logic gate_c;
  assign gate_c = (status_in & ST_GATE_MASK) == ST_GATE_VAL;

  a_r1_ictl_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!ictl_pend && !gate_c) |=> !ictl_pend);
  a_r1_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_pend && !gate_c) |=> !dma_pend);
  a_r2_ictl_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (!ictl_pend && gate_c && status_in[ST_ICTL_EN] && (ictl_stat & ictl_mask) != '0) |=> ictl_pend);
  a_r3_dma_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_pend && gate_c && status_in[ST_DMA_EN] && dmac_stat[DW-1]) |=> dma_pend);
  a_r4_ictl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ictl_pend && !ictl_ack) |=> ictl_pend);
  a_r4_dma_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_pend && dma_ack) |=> !dma_pend);
  a_r4_tmr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_req && !tmr_ack) |=> tmr_req);
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (count_o == $past(count_o) + TW'(1)));
  a_r5_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count_o == $past(wr_data)));
  a_r6_tmr_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_req && status_in[ST_TMR_EN] && count_o >= compare_o
     && count_o < compare_o + TW'(WIN)) |=> tmr_req);
  a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_cause == (tmr_req ? TMR_CAUSE : 32'h0));
  a_r8_pc0_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc0_we && (pcc_in & PC0_SEL_MASK) != PC0_SEL_VAL) |=> $stable(pc0_o));
  a_r9_pc1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc1_we && (pcc_in & PC1_SEL_MASK) != PC1_SEL_VAL) |=> $stable(pc1_o));
endmodule

bind irq_gate_timer irqt_chk #(.IW(IW), .DW(DW), .TW(TW), .WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_in(status_in), .ictl_stat(ictl_stat),
  .ictl_mask(ictl_mask), .dmac_stat(dmac_stat), .dmac_mask(dmac_mask),
  .pcc_in(pcc_in), .wr_data(wr_data), .cnt_we(cnt_we), .pc0_we(pc0_we),
  .pc1_we(pc1_we), .ictl_ack(ictl_ack), .dma_ack(dma_ack), .tmr_ack(tmr_ack),
  .ictl_pend(ictl_pend), .dma_pend(dma_pend), .tmr_req(tmr_req),
  .tmr_cause(tmr_cause), .count_o(count_o), .compare_o(compare_o),
  .pc0_o(pc0_o), .pc1_o(pc1_o)
);

// File: tb/sim_irq_gate_timer.sv
module sim_irq_gate_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] status_in = '0, ictl_stat = '0, ictl_mask = '0, pcc_in = '0, wr_data = '0;
  logic [15:0] dmac_stat = '0, dmac_mask = '0;
  logic cmp_we = 0, cnt_we = 0, pc0_we = 0, pc1_we = 0;
  logic ictl_ack = 0, dma_ack = 0, tmr_ack = 0;
  logic ictl_pend, dma_pend, tmr_req;
  logic [31:0] tmr_cause, count_o, compare_o, pc0_o, pc1_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_gate_timer u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_reqs();
    ictl_stat = '0; dmac_stat = '0; status_in = '0;
    ictl_ack = 1; dma_ack = 1; tmr_ack = 1;
    tick();
    ictl_ack = 0; dma_ack = 0; tmr_ack = 0;
  endtask

  function automatic logic in_win(input logic [31:0] c, input logic [31:0] x);
    logic [31:0] up;
    up = c + 32'd1000;
    return (x >= c) && (x < up);
  endfunction

  task automatic tmr_case(input logic [31:0] c, input logic [31:0] x, input logic en);
    status_in = '0; tmr_ack = 1; cmp_we = 1; wr_data = c;
    tick();
    cmp_we = 0; cnt_we = 1; wr_data = x;
    tick();
    check("R6 compare load", compare_o, c);
    cnt_we = 0; tmr_ack = 0; status_in = en ? 32'h0000_8000 : 32'h0;
    tick();
    check("R6 window", {31'b0, tmr_req}, {31'b0, en && in_win(c, x)});
    check("R7 cause", tmr_cause, (en && in_win(c, x)) ? 32'h0080_8000 : 32'h0);
    status_in = '0;
  endtask

  task automatic pc_case(input logic [31:0] ctl, input logic e0, input logic e1);
    pcc_in = ctl; pc0_we = 1; pc1_we = 1; wr_data = '0;
    tick();
    pc0_we = 0; pc1_we = 0;
    repeat (5) tick();
    check("R8 pc0 count", pc0_o, e0 ? 32'd5 : 32'd0);
    check("R9 pc1 count", pc1_o, e1 ? 32'd5 : 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ictl_pend", {31'b0, ictl_pend}, 32'h0);
    check("R10 dma_pend", {31'b0, dma_pend}, 32'h0);
    check("R10 tmr_req", {31'b0, tmr_req}, 32'h0);
    check("R10 cause", tmr_cause, 32'h0);
    check("R10 count", count_o, 32'h0);
    check("R10 compare", compare_o, 32'h0);
    check("R10 pc0", pc0_o, 32'h0);
    check("R10 pc1", pc1_o, 32'h0);
    rst_n = 1;
    clear_reqs();

    // R1: sweep the four gating bits
    for (int k = 0; k < 16; k++) begin
      logic [31:0] st;
      logic        exp;
      st = 32'h0000_0C00 | {15'b0, k[3], 13'b0, k[2:0]};
      exp = (k == 9);
      status_in = st; ictl_stat = 32'h1; ictl_mask = 32'h1; dmac_stat = 16'h8000;
      tick();
      check("R1 ictl gate", {31'b0, ictl_pend}, {31'b0, exp});
      check("R1 dma gate", {31'b0, dma_pend}, {31'b0, exp});
      clear_reqs();
    end

    // R2: controller status/mask sweep and enable bit
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        status_in = 32'h0001_0401; ictl_stat = 32'h1 << (i * 5); ictl_mask = 32'h1 << (j * 5);
        tick();
        check("R2 ictl match", {31'b0, ictl_pend}, {31'b0, i == j});
        clear_reqs();
      end
    end
    status_in = 32'h0001_0001; ictl_stat = 32'hFFFF_FFFF; ictl_mask = 32'hFFFF_FFFF;
    tick();
    check("R2 ictl enable off", {31'b0, ictl_pend}, 32'h0);
    clear_reqs();

    // R3: DMA status/mask sweep, bit 15 forces
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        status_in = 32'h0001_0801; dmac_stat = 16'h1 << i; dmac_mask = 16'h1 << j;
        tick();
        check("R3 dma match", {31'b0, dma_pend}, {31'b0, (i == j) || (i == 15)});
        clear_reqs();
      end
    end
    status_in = 32'h0001_0001; dmac_stat = 16'h8000; dmac_mask = 16'h0;
    tick();
    check("R3 dma enable off", {31'b0, dma_pend}, 32'h0);
    clear_reqs();

    // R4: hold without ack, drop on ack, re-raise
    status_in = 32'h0001_0401; ictl_stat = 32'h4; ictl_mask = 32'h4;
    tick();
    check("R4 raised", {31'b0, ictl_pend}, 32'h1);
    ictl_stat = '0; status_in = '0;
    repeat (4) tick();
    check("R4 held without ack", {31'b0, ictl_pend}, 32'h1);
    status_in = 32'h0001_0401; ictl_stat = 32'h4; ictl_ack = 1;
    tick();
    ictl_ack = 0;
    check("R4 dropped on ack", {31'b0, ictl_pend}, 32'h0);
    tick();
    check("R4 re-raised", {31'b0, ictl_pend}, 32'h1);
    clear_reqs();

    // R5: load, step, wrap
    cnt_we = 1; wr_data = 32'hFFFF_FFFE;
    tick();
    cnt_we = 0;
    check("R5 count load", count_o, 32'hFFFF_FFFE);
    tick();
    check("R5 count step", count_o, 32'hFFFF_FFFF);
    tick();
    check("R5 count wrap", count_o, 32'h0);
    repeat (7) tick();
    check("R5 count run", count_o, 32'h7);

    // R6/R7: window boundaries including wrapped upper bound
    tmr_case(32'd100, 32'd99, 1);
    tmr_case(32'd100, 32'd100, 1);
    tmr_case(32'd100, 32'd600, 1);
    tmr_case(32'd100, 32'd1099, 1);
    tmr_case(32'd100, 32'd1100, 1);
    tmr_case(32'd100, 32'd500, 0);
    tmr_case(32'hFFFF_FFF0, 32'hFFFF_FFF0, 1);
    tmr_case(32'hFFFF_FFF0, 32'hFFFF_FFFF, 1);
    tmr_case(32'hFFFF_FFF0, 32'h0000_0005, 1);
    tmr_case(32'hFFFF_FC10, 32'hFFFF_FC10, 1);
    tmr_case(32'hFFFF_FC10, 32'hFFFF_FFF7, 1);
    tmr_case(32'hFFFF_FC10, 32'hFFFF_FFF8, 1);
    clear_reqs();

    // R8/R9: control patterns
    pc_case(32'h8000_0020, 1, 0);
    pc_case(32'h0000_0020, 0, 0);
    pc_case(32'h8000_0040, 0, 0);
    pc_case(32'h8000_00A0, 0, 0);
    pc_case(32'hFFF0_7C3F, 1, 0);
    pc_case(32'h8000_8000, 0, 1);
    pc_case(32'h8001_8000, 0, 0);
    pc_case(32'h0000_8000, 0, 0);
    pc_case(32'hFFF0_7FFF & ~32'h0000_03C0 | 32'h0000_8000, 1, 1);
    pc_case(32'h8000_8020, 1, 1);
    pcc_in = 32'h8000_8020; pc0_we = 1; pc1_we = 1; wr_data = 32'h1234_5678;
    tick();
    pc0_we = 0; pc1_we = 0;
    check("R8 pc0 write wins", pc0_o, 32'h1234_5678);
    check("R9 pc1 write wins", pc1_o, 32'h1234_5678);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule